// File: doc/BRIEF.md
# Buffered Input Capture Unit

This block timestamps edges on four input pins against a 16-bit free-running counter. The pins form two pairs. A is the primary of the first pair and C its secondary. B is the primary of the second pair and D its secondary. When a pair is in direct mode, each pin writes the counter value into its own capture register. When a pair is in buffered mode, an event on the primary pin first moves the old primary capture into the secondary register, in the same clock, and then loads the new count into the primary register. This keeps a two-deep history of the primary input. In buffered mode the secondary pin loads no capture value and only raises its flag, so it works as a general external interrupt source.

Each pin passes through a two-stage synchronizer and an edge detector, so an event is recognized two to three clocks after the pin moves. Every pin has its own edge polarity and interrupt enable. Each status flag is managed by its own three-state machine:
- `FLG_IDLE` (clear) goes to `FLG_SET` on a hardware event.
- `FLG_SET` goes to `FLG_ARMED` when software reads the status register.
- `FLG_ARMED` goes back to `FLG_IDLE` when software writes 0 to the flag bit. If a hardware event lands in that same clock, it goes to `FLG_SET` instead.

Every other input combination leaves the flag state unchanged. Software reaches the block through a single-cycle register read/write port. Reads return data combinationally.

Top module: `icu_top`

## Requirements
- R1: After reset, the status register, the counter, all four capture registers and `irq_o` are 0.
- R2: The counter (address 2) rises by one on each clock with `cnt_en_i` high, wraps from 0xFFFF to 0x0000, and is loaded by a software write, which takes priority over counting.
- R3: In direct mode (pair buffer bit 0), an event on any pin copies the counter into that pin's capture register (A=3, B=4, C=5, D=6) and sets that pin's flag. Status is at address 1, with bits [3:0] = flags A, B, C, D.
- R4: In buffered mode (control bit 0 for pair A/C, bit 1 for pair B/D), a primary event moves the previous primary capture into the secondary register, loads the counter into the primary register and sets the primary flag, all in the same clock.
- R5: In buffered mode, a secondary-pin event sets the secondary flag and leaves the secondary capture register unchanged.
- R6: Control bits [5:2] pick the edge for A, B, C and D: 1 selects rising and 0 selects falling. An edge of the other polarity causes no event.
- R7: A write of 1 to a flag leaves it unchanged. A flag clears only when a write of 0 follows a status read made while it was set. A write of 0 with no such read leaves the flag set.
- R8: If an event and a qualifying clear of the same flag occur in the same clock, the flag stays set.
- R9: `irq_o` is the OR of all flags whose enable bit is 1. Control bits [9:6] are the enables for A, B, C and D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en_i | input | 1 | Counter advance enable |
| cap_pin_i | input | 4 | Capture pins A, B, C, D (bits 0 to 3), asynchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (status reads arm flags) |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a qualifying clear that lands in the same clock as a new hardware event on that flag. The stimulus first arms flag B with a status read, then drops pin B with an opposite-polarity edge so no event fires. It then raises the pin one cycle after a clock edge and issues the write of 0 exactly two edges later, which is the cycle in which the synchronized edge is seen. The counter is held still during the capture tests, so every expected capture value is the last value software loaded into the counter.

// File: rtl/icu_pkg.sv
package icu_pkg;
    typedef enum logic [1:0] {
        FLG_IDLE  = 2'd0,
        FLG_SET   = 2'd1,
        FLG_ARMED = 2'd2
    } flg_state_e;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_STAT  = 3'd1,
        REG_COUNT = 3'd2,
        REG_CAPA  = 3'd3,
        REG_CAPB  = 3'd4,
        REG_CAPC  = 3'd5,
        REG_CAPD  = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/icu_edge.sv
module icu_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic evt_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            last_q <= cur;
        end
    end

    always_comb begin
        evt_o = rise_sel_i ? (cur & ~last_q) : (~cur & last_q);
    end
endmodule

// File: rtl/icu_flag.sv
module icu_flag
    import icu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set_i,
    input  logic rd_stat_i,
    input  logic wr_stat_i,
    input  logic wr_bit_i,
    output logic flag_o
);
    flg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE:  if (hw_set_i) state_d = FLG_SET;
            FLG_SET:   if (rd_stat_i) state_d = FLG_ARMED;
            FLG_ARMED: if (wr_stat_i && !wr_bit_i)
                           state_d = hw_set_i ? FLG_SET : FLG_IDLE;
            default:   state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_o = (state_q != FLG_IDLE);
    end

    // R8: a hardware event always leaves the flag set
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set_i |=> flag_o);

    // R7: a flag not yet read cannot be cleared
    p_no_blind_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_SET) |=> flag_o);
endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en_i,
    input  logic [3:0]        cap_pin_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    output logic              irq_o
);
    localparam int NCH    = 4;
    localparam int NPAIR  = NCH / 2;
    localparam int CTRL_W = NPAIR + 2 * NCH;

    logic [CTRL_W-1:0] ctrl_q;
    logic [NPAIR-1:0]  buf_en;
    logic [NCH-1:0]    rise_sel, irq_en, evt, flags;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cap_q [NCH];
    logic              rd_stat, wr_stat, wr_cnt, wr_ctrl;

    assign buf_en   = ctrl_q[NPAIR-1:0];
    assign rise_sel = ctrl_q[NPAIR +: NCH];
    assign irq_en   = ctrl_q[NPAIR+NCH +: NCH];

    assign rd_stat = bus_rd_i && (bus_addr_i == ADDR_W'(REG_STAT));
    assign wr_stat = bus_wr_i && (bus_addr_i == ADDR_W'(REG_STAT));
    assign wr_cnt  = bus_wr_i && (bus_addr_i == ADDR_W'(REG_COUNT));
    assign wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_W'(REG_CTRL));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        icu_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (cap_pin_i[i]),
            .rise_sel_i (rise_sel[i]),
            .evt_o      (evt[i])
        );
        icu_flag u_flag (
            .clk       (clk),
            .rst_n     (rst_n),
            .hw_set_i  (evt[i]),
            .rd_stat_i (rd_stat),
            .wr_stat_i (wr_stat),
            .wr_bit_i  (bus_wdata_i[i]),
            .flag_o    (flags[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata_i[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (wr_cnt)   cnt_q <= bus_wdata_i;
        else if (cnt_en_i) cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) cap_q[i] <= '0;
        end else begin
            for (int p = 0; p < NPAIR; p++) begin
                if (evt[p]) begin
                    cap_q[p] <= cnt_q;
                    if (buf_en[p]) cap_q[p+NPAIR] <= cap_q[p];
                end
                if (evt[p+NPAIR] && !buf_en[p]) cap_q[p+NPAIR] <= cnt_q;
            end
        end
    end

    always_comb begin
        case (bus_addr_i)
            ADDR_W'(REG_CTRL):  bus_rdata_o = CNT_W'(ctrl_q);
            ADDR_W'(REG_STAT):  bus_rdata_o = CNT_W'(flags);
            ADDR_W'(REG_COUNT): bus_rdata_o = cnt_q;
            ADDR_W'(REG_CAPA):  bus_rdata_o = cap_q[0];
            ADDR_W'(REG_CAPB):  bus_rdata_o = cap_q[1];
            ADDR_W'(REG_CAPC):  bus_rdata_o = cap_q[2];
            ADDR_W'(REG_CAPD):  bus_rdata_o = cap_q[3];
            default:            bus_rdata_o = '0;
        endcase
    end

    assign irq_o = |(flags & irq_en);

    // R2: wrap from all-ones to zero
    p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_i && !wr_cnt && cnt_q == '1) |=> (cnt_q == '0));

    for (genvar p = 0; p < NPAIR; p++) begin : g_chk
        // R4: buffered primary event shifts history
        p_buf_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[p] && buf_en[p]) |=>
            (cap_q[p+NPAIR] == $past(cap_q[p]) && cap_q[p] == $past(cnt_q)));
        // R5: secondary register holds in buffered mode without primary event
        p_sec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (buf_en[p] && !evt[p]) |=> $stable(cap_q[p+NPAIR]));
        // R3: direct-mode secondary capture
        p_sec_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[p+NPAIR] && !buf_en[p]) |=> (cap_q[p+NPAIR] == $past(cnt_q)));
    end
endmodule

// File: tb/icu_top_tb_top.sv
`timescale 1ns/1ps
module icu_top_tb_top;
    typedef struct {
        logic [2:0]  addr;
        logic [15:0] exp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [3:0]  pins = 4'h0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    icu_top dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en), .cap_pin_i(pins),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // monitor: compares each read against the queued expectation
    always @(negedge clk) begin
        if (rd && sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (rdata !== it.exp) begin
                n_fail++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, rdata, it.exp);
            end
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, input logic [15:0] e, input string tag);
        exp_t it;
        @(posedge clk); #1;
        addr = a; rd = 1'b1;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic pin(input int idx, input logic v);
        @(posedge clk); #1;
        pins[idx] = v;
        repeat (5) @(posedge clk);
        #1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        n_checks++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk_irq(1'b0, "R1");
        reg_rd(3'd1, 16'h0000, "R1 stat");
        reg_rd(3'd2, 16'h0000, "R1 count");
        reg_rd(3'd3, 16'h0000, "R1 capA");
        reg_rd(3'd6, 16'h0000, "R1 capD");

        // R3 direct capture on A, all rising
        reg_wr(3'd0, 16'h003C);
        reg_wr(3'd2, 16'h1234);
        pin(0, 1'b1);
        reg_rd(3'd3, 16'h1234, "R3 capA");
        reg_rd(3'd1, 16'h0001, "R3 flagA");
        // R7 write of 1 ignored even when armed
        reg_wr(3'd1, 16'h000F);
        reg_rd(3'd1, 16'h0001, "R7 write1");
        reg_wr(3'd1, 16'h0000);
        reg_rd(3'd1, 16'h0000, "R7 clear");

        // R7 write 0 without prior read leaves flag
        reg_wr(3'd2, 16'h0B0B);
        pin(1, 1'b1);
        reg_wr(3'd1, 16'h0000);
        reg_rd(3'd1, 16'h0002, "R7 blind write0");
        reg_wr(3'd1, 16'h0000);
        reg_rd(3'd1, 16'h0000, "R7 clear B");
        reg_rd(3'd4, 16'h0B0B, "R3 capB");

        // R6 opposite edge ignored
        pin(0, 1'b0);
        reg_rd(3'd1, 16'h0000, "R6 falling ignored");
        reg_rd(3'd3, 16'h1234, "R6 capA kept");

        // R4 buffered pair A/C
        reg_wr(3'd0, 16'h003D);
        reg_wr(3'd2, 16'h2222);
        pin(0, 1'b1);
        reg_rd(3'd3, 16'h2222, "R4 capA new");
        reg_rd(3'd5, 16'h1234, "R4 capC history");
        reg_rd(3'd1, 16'h0001, "R4 flagA");
        reg_wr(3'd1, 16'h0000);

        // R5 secondary only flags in buffered mode
        reg_wr(3'd2, 16'h3333);
        pin(2, 1'b1);
        reg_rd(3'd5, 16'h1234, "R5 capC held");
        reg_rd(3'd1, 16'h0004, "R5 flagC");
        reg_wr(3'd1, 16'h0000);

        // R6 falling on C, direct mode
        reg_wr(3'd0, 16'h002C);
        reg_wr(3'd2, 16'h4444);
        pin(2, 1'b0);
        reg_rd(3'd5, 16'h4444, "R6 capC falling");
        reg_rd(3'd1, 16'h0004, "R6 flagC");
        reg_wr(3'd1, 16'h0000);

        // R9 interrupt gating
        reg_wr(3'd0, 16'h022C);
        reg_wr(3'd2, 16'h5555);
        pin(3, 1'b1);
        chk_irq(1'b1, "R9 D enabled");
        reg_rd(3'd6, 16'h5555, "R3 capD");
        reg_rd(3'd1, 16'h0008, "R9 flagD");
        reg_wr(3'd1, 16'h0000);
        chk_irq(1'b0, "R9 cleared");
        pin(1, 1'b0);
        pin(1, 1'b1);
        chk_irq(1'b0, "R9 B masked");
        reg_rd(3'd1, 16'h0002, "R9 flagB");

        // R8 set wins over clear (B is armed)
        pin(1, 1'b0);
        @(posedge clk); #1;
        pins[1] = 1'b1;
        @(posedge clk);
        @(posedge clk); #1;
        addr = 3'd1; wdata = 16'h0000; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
        reg_rd(3'd1, 16'h0002, "R8 set wins");
        reg_wr(3'd1, 16'h0000);
        reg_rd(3'd1, 16'h0000, "R8 later clear");

        // R2 counting and wrap
        reg_wr(3'd2, 16'hFFFE);
        @(posedge clk); #1;
        cnt_en = 1'b1;
        repeat (2) @(posedge clk);
        #1 cnt_en = 1'b0;
        reg_rd(3'd2, 16'h0000, "R2 wrap");
        @(posedge clk); #1;
        cnt_en = 1'b1;
        repeat (3) @(posedge clk);
        #1 cnt_en = 1'b0;
        reg_rd(3'd2, 16'h0003, "R2 count");

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule